// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block runs the external bus transactions of a 16-bit processor. A client presents a request holding an address, write data and one of four transaction kinds: memory read, memory write, port read or port write. The sequencer accepts the request and steps through a fixed series of clock states. The first state publishes the address. The next two assert the read or write strobe. The last state finishes the transaction.

A slow device stretches a transaction by holding the ready input low. Each low sample adds one wait state between the third state and the final one. Read data is captured on the clock edge that enters the final state and is returned to the client together with a one-clock completion pulse. With no request pending, the sequencer stays in idle states. A request that arrives during the final state starts the next transaction immediately. Memory uses a 20-bit address space of 1 MB. Ports use a 16-bit space of 64K.

Top module: `bus_cycle_seq`

## Requirements
- R1: A request is taken (`req_take` high, combinationally) when `req_valid` is high and the sequencer is idle or in its final state, and the address state begins on the next clock. `req_kind` encodes bit 1 = port space and bit 0 = write: 00 memory read, 01 memory write, 10 port read, 11 port write.
- R2: During the address state `bus_ale` is high, and `bus_addr` and `bus_io` show the values registered when the request was taken. Changes on the request inputs after acceptance have no effect on the transaction.
- R3: For port transactions, `bus_addr` bits 19..16 are driven zero. Memory transactions drive all 20 address bits.
- R4: `bus_rd_n` is low in the two strobe states and in every wait state of a read. `bus_wr_n` behaves the same way for a write. Both are high in the address state, the final state and idle, and they are never low together.
- R5: `bus_wdata_oe` is high and `bus_wdata` carries the request's write data during the strobe and wait states of a write. `bus_wdata_oe` is low at all other times.
- R6: `bus_ready` is sampled only at the end of the third state and at the end of each wait state. A high sample moves to the final state and a low sample adds a wait state. A high `bus_ready` in the second state is ignored, so a transaction lasts exactly 4 + (wait states) clocks.
- R7: `rsp_rdata` takes `bus_rdata` as sampled on the edge entering the final state of a read. It keeps that value until the next read completes, and writes leave it unchanged.
- R8: `rsp_done` is high for exactly the one final-state clock of each transaction.
- R9: With no request pending, the sequencer idles: `bus_ale`, `rsp_done`, `bus_io` and `bus_wdata_oe` are low and both strobes are high, whatever `bus_ready` does.
- R10: A request present during the final state begins its address state on the very next clock, with no idle state in between.
- R11: After reset, the sequencer is idle and `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Transaction kind (bit 1 port, bit 0 write) |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_take | output | 1 | Request accepted this clock |
| bus_ready | input | 1 | Device ready, low stretches the transaction |
| bus_rdata | input | DATA_W | Data returned by the device |
| bus_ale | output | 1 | Address state indicator |
| bus_addr | output | ADDR_W | Transaction address |
| bus_io | output | 1 | Port space when high, memory when low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_wdata | output | DATA_W | Write data |
| bus_wdata_oe | output | 1 | Write data valid |
| rsp_rdata | output | DATA_W | Captured read data |
| rsp_done | output | 1 | Transaction completion pulse |

## Verification
Counted from the clock edge on which a request is taken, the address state is visible one clock later and the strobes two and three clocks later. The completion pulse and the read data come 4 + n clocks later, where n is the number of low ready samples. The bench drives every input on the falling edge, waits a short settle delay and samples there. It walks one transaction state per falling edge, so each result is compared in exactly the clock it is due. The sweep covers all four kinds with zero to three wait states and one long stretch. During waits the bench holds a wrong value on the read data input and changes the request inputs after acceptance, so capture on the wrong edge or late latching shows as a miscompare.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    // Transaction kind: bit 1 selects port space, bit 0 selects write
    typedef enum logic [1:0] {
        KIND_MEM_RD = 2'b00,
        KIND_MEM_WR = 2'b01,
        KIND_IO_RD  = 2'b10,
        KIND_IO_WR  = 2'b11
    } kind_e;

    // Clock states of a transaction
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5
    } tstate_e;

    function automatic logic kind_is_write(input logic [1:0] k);
        return k[0];
    endfunction

    function automatic logic kind_is_io(input logic [1:0] k);
        return k[1];
    endfunction

endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    bus_ready,
    output tstate_e state_q,
    output logic    req_take,
    output logic    rdy_edge
);

    typedef struct packed {
        tstate_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d    = fsm_q;
        req_take = 1'b0;
        rdy_edge = 1'b0;
        case (fsm_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    req_take  = 1'b1;
                    fsm_d.st  = ST_T1;
                end
            end
            ST_T1: fsm_d.st = ST_T2;
            ST_T2: fsm_d.st = ST_T3;
            ST_T3, ST_TW: begin
                if (bus_ready) begin
                    rdy_edge = 1'b1;
                    fsm_d.st = ST_T4;
                end else begin
                    fsm_d.st = ST_TW;
                end
            end
            ST_T4: begin
                if (req_valid) begin
                    req_take = 1'b1;
                    fsm_d.st = ST_T1;
                end else begin
                    fsm_d.st = ST_IDLE;
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_q = fsm_q.st;

    // R1
    idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid) |=> (state_q == ST_T1));

    // R10
    chain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T4 && req_valid) |=> (state_q == ST_T1));

    // R6
    t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T1) |=> (state_q == ST_T2));

    // R6
    t2_to_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T2) |=> (state_q == ST_T3));

    // R6
    wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_T3 || state_q == ST_TW) && !bus_ready) |=> (state_q == ST_TW));

    // R6
    wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_T3 || state_q == ST_TW) && bus_ready) |=> (state_q == ST_T4));

endmodule

// File: rtl/bcs_latch.sv
module bcs_latch #(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int IO_ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_take,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              rdy_edge,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [1:0]        kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    import bcs_pkg::*;

    localparam logic [ADDR_W-1:0] IO_MASK = {ADDR_W{1'b1}} >> (ADDR_W - IO_ADDR_W);

    typedef struct packed {
        logic [1:0]        kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (req_take) begin
            lat_d.kind  = req_kind;
            lat_d.addr  = kind_is_io(req_kind) ? (req_addr & IO_MASK) : req_addr;
            lat_d.wdata = req_wdata;
        end
        if (rdy_edge && !kind_is_write(lat_q.kind)) begin
            lat_d.rdata = bus_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign kind_q  = lat_q.kind;
    assign addr_q  = lat_q.addr;
    assign wdata_q = lat_q.wdata;
    assign rdata_q = lat_q.rdata;

    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_take |=> ($stable(addr_q) && $stable(kind_q) && $stable(wdata_q)));

endmodule

// File: rtl/bcs_pins.sv
module bcs_pins #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bcs_pkg::tstate_e  state_q,
    input  logic [1:0]        kind_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    output logic              bus_ale,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_io,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    output logic              rsp_done
);

    import bcs_pkg::*;

    logic in_cycle;
    logic strobe_ph;

    always_comb begin
        in_cycle     = (state_q != ST_IDLE);
        strobe_ph    = (state_q == ST_T2) || (state_q == ST_T3) || (state_q == ST_TW);
        bus_ale      = (state_q == ST_T1);
        bus_addr     = in_cycle ? addr_q : '0;
        bus_io       = in_cycle && kind_is_io(kind_q);
        bus_rd_n     = !(strobe_ph && !kind_is_write(kind_q));
        bus_wr_n     = !(strobe_ph && kind_is_write(kind_q));
        bus_wdata_oe = strobe_ph && kind_is_write(kind_q);
        bus_wdata    = bus_wdata_oe ? wdata_q : '0;
        rsp_done     = (state_q == ST_T4);
    end

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    // R4
    ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (bus_rd_n && bus_wr_n));

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int IO_ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_take,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ale,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_io,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done
);

    import bcs_pkg::*;

    tstate_e           state_q;
    logic              rdy_edge;
    logic [1:0]        kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    bcs_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bus_ready (bus_ready),
        .state_q   (state_q),
        .req_take  (req_take),
        .rdy_edge  (rdy_edge)
    );

    bcs_latch #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .IO_ADDR_W (IO_ADDR_W)
    ) i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_take  (req_take),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rdy_edge  (rdy_edge),
        .bus_rdata (bus_rdata),
        .kind_q    (kind_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata_q   (rsp_rdata)
    );

    bcs_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_q      (state_q),
        .kind_q       (kind_q),
        .addr_q       (addr_q),
        .wdata_q      (wdata_q),
        .bus_ale      (bus_ale),
        .bus_addr     (bus_addr),
        .bus_io       (bus_io),
        .bus_rd_n     (bus_rd_n),
        .bus_wr_n     (bus_wr_n),
        .bus_wdata    (bus_wdata),
        .bus_wdata_oe (bus_wdata_oe),
        .rsp_done     (rsp_done)
    );

    // R3
    io_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale && bus_io) |-> ((bus_addr >> IO_ADDR_W) == '0));

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rsp_rdata) |-> rsp_done);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

// File: tb/test_bus_cycle_seq.sv
`timescale 1ns/1ps
module test_bus_cycle_seq;

    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_take;
    logic          bus_ready = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ale;
    logic [AW-1:0] bus_addr;
    logic          bus_io;
    logic          bus_rd_n;
    logic          bus_wr_n;
    logic [DW-1:0] bus_wdata;
    logic          bus_wdata_oe;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_done;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // next-request globals for chaining in the final state
    bit            nv = 1'b0;
    logic [1:0]    nk = 2'b00;
    logic [AW-1:0] na = '0;
    logic [DW-1:0] nwd = '0;
    logic [DW-1:0] last_rd = '0;

    always #4 clk = ~clk;

    bus_cycle_seq i_bus_cycle_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_kind     (req_kind),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_take     (req_take),
        .bus_ready    (bus_ready),
        .bus_rdata    (bus_rdata),
        .bus_ale      (bus_ale),
        .bus_addr     (bus_addr),
        .bus_io       (bus_io),
        .bus_rd_n     (bus_rd_n),
        .bus_wr_n     (bus_wr_n),
        .bus_wdata    (bus_wdata),
        .bus_wdata_oe (bus_wdata_oe),
        .rsp_rdata    (rsp_rdata),
        .rsp_done     (rsp_done)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(!bus_ale && !rsp_done && !bus_io && !bus_wdata_oe && bus_rd_n && bus_wr_n,
            tag, {26'd0, bus_ale, rsp_done, bus_io, bus_wdata_oe, bus_rd_n, bus_wr_n},
            32'h3);
    endtask

    task automatic chk_strobe(input logic [1:0] k, input logic [DW-1:0] wd, input string tag);
        logic wr;
        wr = k[0];
        chk(bus_rd_n == wr && bus_wr_n == !wr, {tag, " R4 strobe"},
            {30'd0, bus_rd_n, bus_wr_n}, {30'd0, wr, !wr});
        chk(bus_wdata_oe == wr, {tag, " R5 oe"}, {31'd0, bus_wdata_oe}, {31'd0, wr});
        if (wr) chk(bus_wdata == wd, {tag, " R5 wdata"}, {16'd0, bus_wdata}, {16'd0, wd});
        chk(!rsp_done && !bus_ale, {tag, " R6 no early finish"},
            {30'd0, rsp_done, bus_ale}, 32'd0);
    endtask

    // Runs one transaction; issue=0 means it was accepted in the previous final state
    task automatic do_cycle(input logic [1:0] k, input logic [AW-1:0] a,
                            input logic [DW-1:0] wd, input logic [DW-1:0] rd,
                            input int w, input bit issue);
        logic          wr;
        logic          io;
        logic [AW-1:0] ea;
        logic [DW-1:0] exp_rd;
        wr = k[0];
        io = k[1];
        ea = io ? {4'h0, a[15:0]} : a;
        if (issue) begin
            req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
            #1;
            chk(req_take == 1'b1, "R1 take from idle", {31'd0, req_take}, 32'd1);
            @(negedge clk);
        end
        // address state; scramble the request inputs to prove latching
        req_valid = 1'b0; req_kind = ~k; req_addr = ~a; req_wdata = ~wd; bus_ready = 1'b0;
        #1;
        chk(bus_ale == 1'b1, "R2 ale in address state", {31'd0, bus_ale}, 32'd1);
        chk(bus_addr == ea, "R3 address", {12'd0, bus_addr}, {12'd0, ea});
        chk(bus_io == io, "R2 space", {31'd0, bus_io}, {31'd0, io});
        chk(bus_rd_n && bus_wr_n && !bus_wdata_oe, "R4 quiet in address state",
            {30'd0, bus_rd_n, bus_wr_n}, 32'h3);
        chk(!rsp_done, "R8 no done in address state", {31'd0, rsp_done}, 32'd0);
        // second state: ready high here must be ignored
        @(negedge clk);
        bus_ready = 1'b1;
        #1;
        chk_strobe(k, wd, "T2");
        // third state
        @(negedge clk);
        bus_ready = (w == 0);
        bus_rdata = (w == 0) ? rd : ~rd;
        #1;
        chk_strobe(k, wd, "T3 R6 ready in T2 ignored");
        for (int i = 1; i <= w; i++) begin
            @(negedge clk);
            bus_ready = (i == w);
            bus_rdata = (i == w) ? rd : ~rd;
            #1;
            chk_strobe(k, wd, "TW");
            chk(bus_addr == ea, "R2 address held in wait", {12'd0, bus_addr}, {12'd0, ea});
        end
        // final state
        @(negedge clk);
        bus_ready = 1'b0;
        bus_rdata = 16'h0;
        req_valid = nv; req_kind = nk; req_addr = na; req_wdata = nwd;
        #1;
        exp_rd = wr ? last_rd : rd;
        if (!wr) last_rd = rd;
        chk(rsp_done == 1'b1, "R8 done in final state", {31'd0, rsp_done}, 32'd1);
        chk(bus_rd_n && bus_wr_n && !bus_wdata_oe, "R4 R5 quiet in final state",
            {30'd0, bus_rd_n, bus_wr_n}, 32'h3);
        chk(rsp_rdata == exp_rd, "R7 read data", {16'd0, rsp_rdata}, {16'd0, exp_rd});
        chk(req_take == nv, "R10 take in final state", {31'd0, req_take}, {31'd0, nv});
        @(negedge clk);
        if (!nv) begin
            #1;
            chk_idle("R9 idle after transaction");
            chk(rsp_rdata == exp_rd, "R7 read data held", {16'd0, rsp_rdata}, {16'd0, exp_rd});
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk_idle("R11 idle during reset");
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk_idle("R11 idle after reset");
        chk(rsp_rdata == '0, "R11 read data zero", {16'd0, rsp_rdata}, 32'd0);
        chk(req_take == 1'b0, "R11 no take", {31'd0, req_take}, 32'd0);

        // idle with ready toggling and no request
        for (int i = 0; i < 4; i++) begin
            bus_ready = i[0];
            #1;
            chk_idle("R9 idle with ready toggling");
            @(negedge clk);
        end

        // sweep: kind x wait count x two addresses
        nv = 1'b0;
        for (int k = 0; k < 4; k++) begin
            for (int w = 0; w < 4; w++) begin
                for (int j = 0; j < 2; j++) begin
                    logic [AW-1:0] a;
                    logic [DW-1:0] wd;
                    logic [DW-1:0] rd;
                    a  = AW'((32'h9A5C3 * (k * 8 + w * 2 + j + 1)) ^ (j ? 32'hF0000 : 32'h0));
                    wd = DW'(16'h1357 * (k + 1) + w * 16'h0101 + j);
                    rd = DW'(16'hC0DE ^ (k << 12) ^ (w << 4) ^ j);
                    do_cycle(2'(k), a, wd, rd, w, 1'b1);
                end
            end
        end

        // long stretch
        do_cycle(2'b10, 20'hABCDE, 16'h0, 16'h5A5A, 12, 1'b1);

        // back-to-back chain: memory read, port write, port read, memory write
        nv = 1'b1; nk = 2'b11; na = 20'hFFFFF; nwd = 16'hBEEF;
        do_cycle(2'b00, 20'h12345, 16'h0, 16'h7E81, 1, 1'b1);
        nk = 2'b10; na = 20'h5F00D; nwd = 16'h0;
        do_cycle(2'b11, 20'hFFFFF, 16'hBEEF, 16'h0, 0, 1'b0);
        nk = 2'b01; na = 20'h80001; nwd = 16'hA5C3;
        do_cycle(2'b10, 20'h5F00D, 16'h0, 16'h3C3C, 2, 1'b0);
        nv = 1'b0;
        do_cycle(2'b01, 20'h80001, 16'hA5C3, 16'h0, 0, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule